// File: doc/BRIEF.md
# Register bank with pipelined checksum slot

This block is a small bank of byte-wide registers that a host reaches through a plain memory-style port: one address, a write strobe with write data, and a read strobe whose data comes back on the next clock. All but the top entry are ordinary registers that the host can write and read back.

The top entry is read-only to the host. Hardware keeps it loaded with the 8-bit wrapping sum of every other entry. The sum comes from a balanced adder tree that has a register after each level, so the path from the source entries to the result slot is always broken into short steps. The slot takes the tree output on every clock in which the read strobe is low. While the read strobe is high, the slot holds its value so that a read sees a steady result. After changing the operands, the host waits a fixed number of cycles before it reads the result.

With the default 20 entries, the tree has five levels and the slot load adds one more register, for a total latency of six cycles. The result is therefore settled seven cycles after the last write.

Top module: `sumslot_regbank`

## Requirements
- R1: While rst_ni is low, every entry, every tree register and rd_data_o are zero. After release, every address reads zero until a write occurs.
- R2: A write (wr_en_i high) to an address from 0 to 18 stores wr_data_i into that entry at the clock edge, and a later read returns it.
- R3: A write to address 19, the result slot, leaves every entry unchanged.
- R4: When rd_en_i is high at an edge, rd_data_o shows the addressed entry's pre-edge value from that edge on. When rd_en_i is low, rd_data_o holds its value.
- R5: Entry 19 equals (sum of entries 0 to 18) mod 256 no later than 7 clock edges after the last write, provided rd_en_i stays low through those edges.
- R6: At every edge where rd_en_i is high, entry 19 keeps its value. The tree keeps advancing during that time, and the slot resumes loading once the strobe drops.
- R7: Addresses 20 to 31 are not mapped. A write to one of them changes nothing, and a read of one returns zero.
- R8: When a read and a write target the same address in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Entry address for a read or a write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe; also freezes the result slot |
| rd_data_o | output | 8 | Registered read data |

## Verification
The assertions assume that the strobes and the address are never unknown after reset, and that the inputs are driven low while reset is asserted, because their $past terms look back one cycle into reset. The stimulus changes inputs only on falling clock edges and holds them at zero during reset. It mixes directed sequences (unmapped addresses, writes to the slot, long read bursts, and a read and a write to the same address) with a random phase. In the random phase, the read strobe is high often enough to freeze the slot and low often enough for the slot to refresh.

// File: rtl/sumslot_regbank_pkg.sv
package sumslot_regbank_pkg;
  localparam int DEF_ENTRIES = 20;
  localparam int DEF_DATA_W  = 8;

  // levels of a balanced binary tree over n operands
  function automatic int tree_levels(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // source-entry write to result-slot load, in cycles
  function automatic int pipe_latency(input int n);
    return tree_levels(n) + 1;
  endfunction
endpackage

// File: rtl/sumslot_tree.sv
module sumslot_tree #(
  parameter int N_OPS  = 19,
  parameter int DATA_W = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_OPS-1:0][DATA_W-1:0] ops_i,
  output logic [DATA_W-1:0]            sum_o
);
  import sumslot_regbank_pkg::*;

  localparam int LEVELS = tree_levels(N_OPS);
  localparam int LEAVES = 1 << LEVELS;

  logic [LEAVES-1:0][DATA_W-1:0] leaf;

  always_comb begin
    leaf = '0;
    leaf[N_OPS-1:0] = ops_i;
  end

  for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
    localparam int NODES = LEAVES >> k;
    logic [NODES-1:0][DATA_W-1:0]   node_q;
    logic [2*NODES-1:0][DATA_W-1:0] src;

    if (k == 1) begin : g_from_leaf
      assign src = leaf;
    end else begin : g_from_lvl
      assign src = g_lvl[k-1].node_q;
    end

    // sums wrap at DATA_W bits on purpose
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        node_q <= '0;
      end else begin
        for (int n = 0; n < NODES; n++) begin
          node_q[n] <= src[2*n] + src[2*n+1];
        end
      end
    end
  end

  assign sum_o = g_lvl[LEVELS].node_q[0];
endmodule

// File: rtl/sumslot_store.sv
module sumslot_store #(
  parameter int N_ENTRIES = 20,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             wr_en_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             hold_i,
  input  logic [DATA_W-1:0]                sum_i,
  output logic [N_ENTRIES-1:0][DATA_W-1:0] entries_o
);
  localparam int SLOT = N_ENTRIES - 1;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic [DATA_W-1:0] ent_q;

    if (i == SLOT) begin : g_slot
      // host writes never reach the slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ent_q <= '0;
        else if (!hold_i) ent_q <= sum_i;
      end
    end else begin : g_host
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                               ent_q <= '0;
        else if (wr_en_i && addr_i == ADDR_W'(i))  ent_q <= wr_data_i;
      end
    end

    assign entries_o[i] = ent_q;
  end
endmodule

// File: rtl/sumslot_rdport.sv
module sumslot_rdport #(
  parameter int N_ENTRIES = 20,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic                             rd_en_i,
  input  logic [N_ENTRIES-1:0][DATA_W-1:0] entries_i,
  output logic [DATA_W-1:0]                rd_data_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (addr_i == ADDR_W'(i)) sel = entries_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= sel;
  end
endmodule

// File: rtl/sumslot_regbank.sv
module sumslot_regbank #(
  parameter int N_ENTRIES = sumslot_regbank_pkg::DEF_ENTRIES,
  parameter int DATA_W    = sumslot_regbank_pkg::DEF_DATA_W,
  parameter int ADDR_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int N_OPS = N_ENTRIES - 1;

  logic [N_ENTRIES-1:0][DATA_W-1:0] entries_q;
  logic [DATA_W-1:0]                tree_sum;
  logic [DATA_W-1:0]                slot_val;

  assign slot_val = entries_q[N_ENTRIES-1];

  sumslot_store #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .hold_i    (rd_en_i),
    .sum_i     (tree_sum),
    .entries_o (entries_q)
  );

  sumslot_tree #(.N_OPS(N_OPS), .DATA_W(DATA_W)) u_tree (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ops_i  (entries_q[N_OPS-1:0]),
    .sum_o  (tree_sum)
  );

  sumslot_rdport #(.N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdport (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .rd_en_i   (rd_en_i),
    .entries_i (entries_q),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/sumslot_regbank_chk.sv
module sumslot_regbank_chk #(
  parameter int N_ENTRIES = 20,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 5
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [ADDR_W-1:0]                addr_i,
  input logic                             wr_en_i,
  input logic [DATA_W-1:0]                wr_data_i,
  input logic                             rd_en_i,
  input logic [DATA_W-1:0]                rd_data_o,
  input logic [DATA_W-1:0]                slot_i,
  input logic [N_ENTRIES-1:0][DATA_W-1:0] entries_i
);
  localparam int SLOT = N_ENTRIES - 1;

  // R2
  host_write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) < SLOT) |=> entries_i[$past(addr_i)] == $past(wr_data_i));

  // R3
  slot_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(addr_i) >= SLOT) |=> $stable(entries_i[SLOT-1:0]));

  // R4
  read_returns_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && int'(addr_i) < N_ENTRIES) |=> rd_data_o == $past(entries_i[addr_i]));

  // R4
  read_data_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R6
  slot_frozen_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> $stable(slot_i));

  // R7
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && int'(addr_i) >= N_ENTRIES) |=> rd_data_o == '0);
endmodule

bind sumslot_regbank sumslot_regbank_chk #(
  .N_ENTRIES(N_ENTRIES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .rd_data_o (rd_data_o),
  .slot_i    (slot_val),
  .entries_i (entries_q)
);

// File: tb/sumslot_regbank_tb.sv
module sumslot_regbank_tb;
  localparam int N   = 20;
  localparam int LAT = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  int unsigned m[N];
  logic [7:0]  m_rd;
  int unsigned hist[$];

  always #2 clk = ~clk;

  sumslot_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data)
  );

  function automatic int unsigned ref_sum();
    int unsigned s = 0;
    for (int i = 0; i < N - 1; i++) s += m[i];
    return s & 8'hff;
  endfunction

  // behavioural model of the port, advanced at every rising edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m[i]) m[i] = 0;
      m_rd = '0;
      hist.delete();
      for (int i = 0; i < LAT; i++) hist.push_back(0);
    end else begin
      int unsigned front;
      if (rd_en) m_rd = (int'(addr) < N) ? 8'(m[addr]) : 8'h00;
      front = hist.pop_front();
      if (!rd_en) m[N-1] = front;
      if (wr_en && int'(addr) < N - 1) m[addr] = wr_data;
      hist.push_back(ref_sum());
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rd_data act=%02h exp=%02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) check(cur_req, rd_data, m_rd);
  end

  task automatic cyc(bit we, bit re, logic [4:0] a, logic [7:0] d);
    wr_en = we; rd_en = re; addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1", rd_data, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: everything reads zero after reset
    cur_req = "R1";
    for (int a = 0; a < N; a++) begin
      cyc(0, 1, 5'(a), '0);
      check("R1", rd_data, 8'h00);
    end

    // R2: fill operands, read back
    cur_req = "R2";
    for (int a = 0; a < N - 1; a++) cyc(1, 0, 5'(a), 8'($urandom));
    for (int a = 0; a < N - 1; a++) begin
      cyc(0, 1, 5'(a), '0);
      check("R2", rd_data, 8'(m[a]));
    end

    // R5: settle, then read the slot
    cur_req = "R5";
    cyc(1, 0, 5'd7, 8'hff);
    idle(LAT + 1);
    cyc(0, 1, 5'd19, '0);
    check("R5", rd_data, 8'(ref_sum()));

    // R3: write into the slot has no effect
    cur_req = "R3";
    held = 8'(ref_sum()) ^ 8'h5a;
    cyc(1, 0, 5'd19, held);
    idle(LAT + 1);
    cyc(0, 1, 5'd19, '0);
    check("R3", rd_data, 8'(ref_sum()));
    for (int a = 0; a < N - 1; a++) begin
      cyc(0, 1, 5'(a), '0);
      check("R3", rd_data, 8'(m[a]));
    end

    // R6: long read burst freezes slot while operands change
    cur_req = "R6";
    cyc(0, 1, 5'd19, '0);
    held = rd_data;
    cyc(1, 0, 5'd0, 8'(m[0] + 1));
    cyc(0, 1, 5'd19, '0);
    held = rd_data;
    for (int i = 0; i < 12; i++) begin
      cyc(0, 1, 5'd19, '0);
      check("R6", rd_data, held);
    end
    idle(LAT + 1);
    cyc(0, 1, 5'd19, '0);
    check("R6", rd_data, 8'(ref_sum()));

    // R4: read data holds with strobe low
    cur_req = "R4";
    cyc(0, 1, 5'd4, '0);
    held = rd_data;
    check("R4", held, 8'(m[4]));
    cyc(1, 0, 5'd4, ~held);
    idle(3);
    check("R4", rd_data, held);

    // R7: unmapped addresses
    cur_req = "R7";
    for (int a = N; a < 32; a++) cyc(1, 0, 5'(a), 8'hc3);
    for (int a = N; a < 32; a++) begin
      cyc(0, 1, 5'(a), '0);
      check("R7", rd_data, 8'h00);
    end
    for (int a = 0; a < N - 1; a++) begin
      cyc(0, 1, 5'(a), '0);
      check("R7", rd_data, 8'(m[a]));
    end

    // R8: read and write to the same address together
    cur_req = "R8";
    held = 8'(m[3]);
    cyc(1, 1, 5'd3, ~held);
    check("R8", rd_data, held);
    cyc(0, 1, 5'd3, '0);
    check("R8", rd_data, ~held);

    // mixed random traffic, compared each cycle
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0, 5'($urandom), 8'($urandom));
    end
    idle(LAT + 1);
    cyc(0, 1, 5'd19, '0);
    check("R5", rd_data, 8'(ref_sum()));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule